// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Conditionally Latched Status Flags

This block is the arithmetic core of a small multi-cycle processor. Two operands and a four-bit operation code go in. A result comes out in the same cycle, with no register on the path. Alongside the result, the block computes four condition indications: zero, carry, negative and signed overflow.

The condition indications pass into a status register that loads only on a clock edge where the update enable is high. The controller raises the enable for arithmetic and logic instructions only. Loads, stores and branches leave the enable low, so the outcome of the last comparison stays available to a later conditional branch. A synchronous reset clears the status register.

Top module: `alu_flagged`

## Requirements
- R1: With `op_sel` = 0 (add), `result` equals `op_a + op_b` modulo 2^WIDTH. The captured carry is the carry out of bit WIDTH-1. The captured overflow is set when both operands have the same sign and the result's sign differs from it.
- R2: With `op_sel` = 1 (subtract), `result` equals `op_a - op_b` modulo 2^WIDTH. The captured carry is 1 exactly when `op_a >= op_b` as unsigned numbers, meaning no borrow occurred. The captured overflow is set when the operand signs differ and the result's sign differs from that of `op_a`.
- R3: With `op_sel` = 2, 3 or 4, `result` is the bitwise AND, OR or XOR of the operands, and the captured carry and overflow are 0.
- R4: With `op_sel` = 5, `result` is the bitwise inverse of `op_a`. With `op_sel` = 8, `result` equals `op_b`. For both codes the captured carry and overflow are 0.
- R5: With `op_sel` = 6, `result` is `op_a` shifted left by one with a 0 filled in, and the carry takes the old bit WIDTH-1. With `op_sel` = 7, `result` is `op_a` shifted right logically by one, and the carry takes the old bit 0. For both codes the overflow is 0.
- R6: On every capture, the zero flag is 1 exactly when `result` is all zeros, and the negative flag equals bit WIDTH-1 of `result`.
- R7: On a rising clock edge with `flag_we` = 1 and `rst` = 0, the four flags take the values computed from that cycle's inputs. With `flag_we` = 0 the flags keep their previous values, whatever `op_sel` and the operands are.
- R8: A rising clock edge with `rst` = 1 clears all four flags, even when `flag_we` = 1. The flags read 0 after reset.
- R9: For the unused codes 9 to 15, `result` is 0. A capture on one of these codes gives zero = 1 and carry = overflow = negative = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the status register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the status flags |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_sel | input | 4 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 not A, 6 shl A, 7 shr A, 8 pass B) |
| flag_we | input | 1 | Capture the new flags at the next rising edge |
| result | output | WIDTH | Combinational operation result |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry / no-borrow / shifted-out flag |
| flag_n | output | 1 | Registered negative flag |
| flag_v | output | 1 | Registered signed-overflow flag |

## Verification
`result` is combinational, so it is due in the same cycle as its inputs. The bench drives each vector on a falling edge and reads `result` one time unit later, before the next rising edge. The flags are due one rising edge after the vector; they are read at the following falling edge, which is also where the next vector is driven. Hold and reset checks follow the same cadence: each compares the flags one edge after an edge with `flag_we` low or `rst` high.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_OR    = 4'd3,
        OP_XOR   = 4'd4,
        OP_NOT   = 4'd5,
        OP_SHL   = 4'd6,
        OP_SHR   = 4'd7,
        OP_PASSB = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic v;
    } alu_flags_t;

    localparam alu_flags_t FLAGS_CLEAR = '0;

    // Codes whose carry and overflow are forced low
    function automatic logic clears_cv(input logic [3:0] op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) ||
               (op == OP_NOT) || (op == OP_PASSB) || (op > OP_PASSB);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;

    always_comb begin
        b_eff = sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        sum   = full[MSB:0];
        cout  = full[WIDTH];
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       op_sel,
    output logic [WIDTH-1:0] res,
    output alu_flags_t       flags_next
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] as_sum;
    logic             as_cout;
    logic             as_ovf;
    logic             c_raw;
    logic             v_raw;

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a    (op_a),
        .b    (op_b),
        .sub  (op_sel == OP_SUB),
        .sum  (as_sum),
        .cout (as_cout),
        .ovf  (as_ovf)
    );

    always_comb begin
        res   = '0;
        c_raw = 1'b0;
        v_raw = 1'b0;
        case (op_sel)
            OP_ADD, OP_SUB: begin
                res   = as_sum;
                c_raw = as_cout;
                v_raw = as_ovf;
            end
            OP_AND:   res = op_a & op_b;
            OP_OR:    res = op_a | op_b;
            OP_XOR:   res = op_a ^ op_b;
            OP_NOT:   res = ~op_a;
            OP_SHL: begin
                res   = {op_a[MSB-1:0], 1'b0};
                c_raw = op_a[MSB];
            end
            OP_SHR: begin
                res   = {1'b0, op_a[MSB:1]};
                c_raw = op_a[0];
            end
            OP_PASSB: res = op_b;
            default:  res = '0;
        endcase
        flags_next.z = (res == '0);
        flags_next.c = c_raw;
        flags_next.n = res[MSB];
        flags_next.v = v_raw;
    end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  alu_flags_t d,
    output alu_flags_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= FLAGS_CLEAR;
        else if (we)
            q <= d;
    end

    // R7: no enable, no change
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

    // R7: enable loads the value offered at that edge
    p_capture_r7: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(d)));

    // R8: reset wins over enable
    p_reset_r8: assert property (@(posedge clk)
        rst |=> (q == FLAGS_CLEAR));

endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       op_sel,
    input  logic             flag_we,
    output logic [WIDTH-1:0] result,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_n,
    output logic             flag_v
);
    localparam int MSB = WIDTH - 1;

    alu_flags_t flags_next;
    alu_flags_t flags_q;

    alu_core #(.WIDTH(WIDTH)) u_core (
        .op_a       (op_a),
        .op_b       (op_b),
        .op_sel     (op_sel),
        .res        (result),
        .flags_next (flags_next)
    );

    alu_flag_reg u_flags (
        .clk (clk),
        .rst (rst),
        .we  (flag_we),
        .d   (flags_next),
        .q   (flags_q)
    );

    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_n = flags_q.n;
    assign flag_v = flags_q.v;

    // R3 / R4: logic and move codes leave carry and overflow low
    p_logic_cv_r3: assert property (@(posedge clk) disable iff (rst)
        (flag_we && clears_cv(op_sel)) |=> (!flag_c && !flag_v));

    // R6: a zero result produces a set zero flag
    p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (flag_we && (result == '0)) |=> flag_z);

    // R6: negative flag follows the result sign bit
    p_neg_flag_r6: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flag_n == $past(result[MSB])));

    // R9: unused codes give a zero result
    p_unused_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (op_sel > OP_PASSB) |-> (result == '0));

endmodule

// File: tb/alu_flagged_bench.sv
module alu_flagged_bench;
    localparam int W = 8;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [3:0]   op_sel = '0;
    logic         flag_we = 1'b0;
    logic [W-1:0] result;
    logic         flag_z, flag_c, flag_n, flag_v;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    alu_flagged #(.WIDTH(W)) u_alu_flagged (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .flag_we(flag_we), .result(result), .flag_z(flag_z), .flag_c(flag_c),
        .flag_n(flag_n), .flag_v(flag_v)
    );

    // Reference model derived from the requirement text
    function automatic logic [W+3:0] model(input logic [3:0] op,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        logic [W:0]   s;
        logic [W-1:0] r;
        logic         c, v;
        r = '0; c = 1'b0; v = 1'b0;
        case (op)
            4'd0: begin
                s = {1'b0, a} + {1'b0, b};
                r = s[W-1:0]; c = s[W];
                v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
            end
            4'd1: begin
                r = a - b; c = (a >= b);
                v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
            end
            4'd2: r = a & b;
            4'd3: r = a | b;
            4'd4: r = a ^ b;
            4'd5: r = ~a;
            4'd6: begin r = a << 1; c = a[W-1]; end
            4'd7: begin r = a >> 1; c = a[0]; end
            4'd8: r = b;
            default: r = '0;
        endcase
        return {r, (r == '0), c, r[W-1], v};
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd5, 4'd8: return "R4";
            4'd6, 4'd7: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic check_flags(input string req, input logic [3:0] exp);
        n_run++;
        if ({flag_z, flag_c, flag_n, flag_v} !== exp) begin
            n_fail++;
            $display("FAIL %s flags zcnv actual=%b expected=%b", req,
                     {flag_z, flag_c, flag_n, flag_v}, exp);
        end
    endtask

    // Drive at a falling edge, check result, let one rising edge pass,
    // check flags at the next falling edge.
    task automatic apply(input logic [3:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b);
        logic [W+3:0] e;
        e = model(op, a, b);
        op_sel = op; op_a = a; op_b = b; flag_we = 1'b1;
        #1;
        n_run++;
        if (result !== e[W+3:4]) begin
            n_fail++;
            $display("FAIL %s result op=%0d a=%0d b=%0d actual=%0d expected=%0d",
                     req_of(op), op, a, b, result, e[W+3:4]);
        end
        @(posedge clk);
        @(negedge clk);
        check_flags(req_of(op), e[3:0]);
        if (op <= 4'd8) check_flags("R6", {(e[W+3:4] == '0), flag_c, e[W+3], flag_v});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        logic [3:0] held;
        repeat (2) @(negedge clk);
        check_flags("R8", 4'b0000);
        rst = 1'b0;

        for (int a = 0; a <= MAXV; a++)
            for (int b = 0; b <= MAXV; b += 5) begin
                apply(4'd0, a[W-1:0], b[W-1:0]);
                apply(4'd1, a[W-1:0], b[W-1:0]);
            end
        // R1 / R2 corners
        apply(4'd0, 8'h7F, 8'h01);
        apply(4'd0, 8'h80, 8'h80);
        apply(4'd1, 8'h80, 8'h01);
        apply(4'd1, 8'h05, 8'h05);
        apply(4'd1, 8'h04, 8'h05);

        for (int op = 2; op <= 8; op++) begin
            if (op == 5 || op == 6 || op == 7) begin
                for (int a = 0; a <= MAXV; a++)
                    apply(op[3:0], a[W-1:0], 8'h3C);
            end else begin
                for (int a = 0; a <= MAXV; a += 3)
                    for (int b = 0; b <= MAXV; b += 7)
                        apply(op[3:0], a[W-1:0], b[W-1:0]);
            end
        end

        for (int op = 9; op <= 15; op++)
            for (int k = 0; k < 8; k++)
                apply(op[3:0], 8'hFF - k[W-1:0], 8'h81 + k[W-1:0]);

        // R7: hold with enable low under changing inputs
        apply(4'd1, 8'h80, 8'h01);           // flags z=0 c=1 n=0 v=1
        held = {flag_z, flag_c, flag_n, flag_v};
        for (int op = 0; op <= 8; op++) begin
            op_sel = op[3:0]; op_a = 8'h00; op_b = 8'hFF; flag_we = 1'b0;
            @(posedge clk);
            @(negedge clk);
            check_flags("R7", held);
        end

        // R8: reset overrides enable
        apply(4'd0, 8'hFF, 8'h01);           // z=1 c=1
        op_sel = 4'd0; op_a = 8'hFF; op_b = 8'h81; flag_we = 1'b1; rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_flags("R8", 4'b0000);
        rst = 1'b0; flag_we = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule